// File: doc/BRIEF.md
# Block Write-Protection Lock Controller

This block holds the write-protection state of every erase block in a NAND-style flash array. Each block is locked, unlocked or lock-tight. Lock-tight is a one-way state. Only a locked block can enter it, and no command can take a block out of it. The program and erase paths of the array read a block's state through a query port before they act on that block.

Software sets a range with two registers, a first block and a last block. It then issues one of four opcodes: range unlock, unlock all, range lock or range lock-tight. The controller walks the range one block per clock while `busy` is high. It closes each walk with a one-cycle `done` pulse, which the interrupt logic uses. A status output holds the state most recently written into a block. An error flag reports a walk that ran past the last block of the array.

Top module: `wp_lock_ctrl`

## Requirements
- R1: A synchronous reset puts every block in the locked state and `wp_status` at 3'b010. It clears `cmd_err`, `busy` and `done`, and sets both range registers to 0.
- R2: The states are one-hot: lock-tight = 3'b001, locked = 3'b010, unlocked = 3'b100. `q_state` shows the state of block `q_idx` one clock after `q_idx` is sampled. It shows 3'b000 when `q_idx` is not below NUM_BLK.
- R3: Opcode 8'h23 unlocks each block from `range_start` to `range_end` inclusive, in ascending order, one block per clock. Lock-tight blocks are left unchanged.
- R4: Opcode 8'h27 walks blocks 0 to NUM_BLK-1 and unlocks every block that is not lock-tight.
- R5: Opcode 8'h2a locks each block of the range. Lock-tight blocks are left unchanged.
- R6: Opcode 8'h2c moves locked blocks of the range to lock-tight. Lock-tight blocks are written again as lock-tight. Unlocked blocks stay unlocked.
- R7: `wp_status` takes the new state of every block the walk writes. Skipped blocks leave it unchanged, and it never changes outside a walk.
- R8: A register write with `reg_sel`=0 loads the first-block register and copies the same value into the last-block register. A write with `reg_sel`=1 loads only the last-block register. Both keep only the low IDXW bits of `reg_wdata`, where IDXW = clog2(NUM_BLK).
- R9: A walk that reaches an index not below NUM_BLK sets `cmd_err` and ends there. Blocks below that index are still updated. A first block above the last block touches no block and sets no error. `cmd_err` clears when the next command is accepted.
- R10: After an accepted command, `busy` is high from the next clock for one cycle per visited block plus one. `done` pulses for one cycle in the cycle `busy` drops.
- R11: A command presented while `busy` is high, or with an opcode other than the four above, is ignored. No state, status or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Range register write strobe |
| reg_sel | input | 1 | 0 = first-block register (also copies to last), 1 = last-block register |
| reg_wdata | input | DW | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| q_idx | input | IDXW | Block index to query |
| q_state | output | 3 | Registered state of the queried block |
| range_start | output | IDXW | First-block register |
| range_end | output | IDXW | Last-block register |
| wp_status | output | 3 | State last written by a walk |
| busy | output | 1 | Range walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| cmd_err | output | 1 | A walk ran beyond the last block |

## Verification
The bench builds the block with NUM_BLK = 12 and DW = 16, so IDXW is 4. Range registers can then hold 12 to 15, which is what makes the out-of-range error of R9 reachable through the normal register path. At the default of 16 blocks the masked registers cannot address a missing block. A behavioural model follows the same walk clock by clock, so the exact busy length and the `done` cycle are checked on every walk, along with the skip rules of each opcode on mixed ranges. Directed queries confirm individual block states after each scenario.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;

  typedef enum logic [2:0] {
    WP_TIGHT    = 3'b001,
    WP_LOCKED   = 3'b010,
    WP_UNLOCKED = 3'b100
  } wp_state_e;

  typedef enum logic [1:0] {
    ACT_UNLOCK = 2'd0,
    ACT_LOCK   = 2'd1,
    ACT_TIGHT  = 2'd2
  } wp_act_e;

  localparam logic [7:0] OP_UNL_RANGE   = 8'h23;
  localparam logic [7:0] OP_UNL_ALL     = 8'h27;
  localparam logic [7:0] OP_LOCK_RANGE  = 8'h2a;
  localparam logic [7:0] OP_TIGHT_RANGE = 8'h2c;

  typedef struct packed {
    logic      wr;
    wp_state_e nxt;
  } wp_upd_t;

  // Transition rule for one block under one walk action.
  function automatic wp_upd_t wp_rule(input wp_state_e cur, input wp_act_e act);
    wp_upd_t r;
    r.wr  = 1'b0;
    r.nxt = cur;
    case (act)
      ACT_UNLOCK: if (cur != WP_TIGHT) begin
        r.wr  = 1'b1;
        r.nxt = WP_UNLOCKED;
      end
      ACT_LOCK: if (cur != WP_TIGHT) begin
        r.wr  = 1'b1;
        r.nxt = WP_LOCKED;
      end
      ACT_TIGHT: if (cur != WP_UNLOCKED) begin
        r.wr  = 1'b1;
        r.nxt = WP_TIGHT;
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
  parameter int IDXW = 4,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            sel,
  input  logic [DW-1:0]   wdata,
  output logic [IDXW-1:0] first_q,
  output logic [IDXW-1:0] last_q
);

  logic [IDXW-1:0] val;
  logic            unused_hi;

  assign val       = wdata[IDXW-1:0];
  assign unused_hi = ^wdata[DW-1:IDXW];

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (wr) begin
      last_q <= val;
      if (!sel) first_q <= val;
    end
  end

endmodule

// File: rtl/wp_walk_seq.sv
module wp_walk_seq
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int IDXW    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_op,
  input  logic [IDXW-1:0] first_i,
  input  logic [IDXW-1:0] last_i,
  output logic            upd_en,
  output logic [IDXW-1:0] upd_idx,
  output wp_act_e         upd_act,
  output logic            busy,
  output logic            done,
  output logic            err
);

  localparam int CW = IDXW + 1;
  localparam logic [CW-1:0] BLK_CNT  = CW'(NUM_BLK);
  localparam logic [CW-1:0] BLK_LAST = CW'(NUM_BLK - 1);

  logic [CW-1:0] cur;
  logic [CW-1:0] hi;
  wp_act_e       act_q;

  logic          acc;
  wp_act_e       act_d;
  logic [CW-1:0] lo_d;
  logic [CW-1:0] hi_d;

  always_comb begin
    acc   = 1'b0;
    act_d = ACT_UNLOCK;
    lo_d  = {1'b0, first_i};
    hi_d  = {1'b0, last_i};
    if (cmd_valid && !busy) begin
      case (cmd_op)
        OP_UNL_RANGE:   begin acc = 1'b1; act_d = ACT_UNLOCK; end
        OP_UNL_ALL:     begin acc = 1'b1; act_d = ACT_UNLOCK; lo_d = '0; hi_d = BLK_LAST; end
        OP_LOCK_RANGE:  begin acc = 1'b1; act_d = ACT_LOCK;   end
        OP_TIGHT_RANGE: begin acc = 1'b1; act_d = ACT_TIGHT;  end
        default: ;
      endcase
    end
  end

  logic in_range;
  logic past_end;
  assign in_range = (cur <= hi);
  assign past_end = (cur >= BLK_CNT);

  assign upd_en  = busy && in_range && !past_end;
  assign upd_idx = cur[IDXW-1:0];
  assign upd_act = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= '0;
      hi    <= '0;
      act_q <= ACT_UNLOCK;
      busy  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (!in_range) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (past_end) begin
          err  <= 1'b1;
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cur <= cur + 1'b1;
        end
      end else if (acc) begin
        cur   <= lo_d;
        hi    <= hi_d;
        act_q <= act_d;
        busy  <= 1'b1;
        err   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wp_state_array.sv
module wp_state_array
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int IDXW    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_en,
  input  logic [IDXW-1:0] upd_idx,
  input  wp_act_e         upd_act,
  input  logic [IDXW-1:0] q_idx,
  output logic [2:0]      q_state,
  output logic            wr_hit,
  output logic [2:0]      wr_val
);

  localparam int CW = IDXW + 1;

  wp_state_e st_all  [NUM_BLK];
  wp_upd_t   upd_all [NUM_BLK];
  logic [NUM_BLK-1:0] hit;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    wp_state_e st;
    assign upd_all[g] = wp_rule(st, upd_act);
    assign hit[g]     = upd_en && (upd_idx == IDXW'(g)) && upd_all[g].wr;

    always_ff @(posedge clk) begin
      if (rst)         st <= WP_LOCKED;
      else if (hit[g]) st <= upd_all[g].nxt;
    end

    assign st_all[g] = st;
  end

  always_comb begin
    wr_hit = 1'b0;
    wr_val = 3'b000;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (hit[i]) begin
        wr_hit = 1'b1;
        wr_val = upd_all[i].nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              q_state <= 3'b000;
    else if ({1'b0, q_idx} < CW'(NUM_BLK)) q_state <= st_all[q_idx];
    else                                  q_state <= 3'b000;
  end

endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
  import wp_lock_pkg::*;
#(
  parameter int  NUM_BLK = 16,
  parameter int  DW      = 16,
  localparam int IDXW    = $clog2(NUM_BLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_op,
  input  logic [IDXW-1:0] q_idx,
  output logic [2:0]      q_state,
  output logic [IDXW-1:0] range_start,
  output logic [IDXW-1:0] range_end,
  output logic [2:0]      wp_status,
  output logic            busy,
  output logic            done,
  output logic            cmd_err
);

  logic            upd_en;
  logic [IDXW-1:0] upd_idx;
  wp_act_e         upd_act;
  logic            wr_hit;
  logic [2:0]      wr_val;

  wp_range_regs #(.IDXW(IDXW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .first_q (range_start),
    .last_q  (range_end)
  );

  wp_walk_seq #(.NUM_BLK(NUM_BLK), .IDXW(IDXW)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .first_i   (range_start),
    .last_i    (range_end),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_act   (upd_act),
    .busy      (busy),
    .done      (done),
    .err       (cmd_err)
  );

  wp_state_array #(.NUM_BLK(NUM_BLK), .IDXW(IDXW)) u_arr (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .upd_idx (upd_idx),
    .upd_act (upd_act),
    .q_idx   (q_idx),
    .q_state (q_state),
    .wr_hit  (wr_hit),
    .wr_val  (wr_val)
  );

  always_ff @(posedge clk) begin
    if (rst)         wp_status <= WP_LOCKED;
    else if (wr_hit) wp_status <= wr_val;
  end

endmodule

// File: rtl/wp_lock_chk.sv
module wp_lock_chk #(
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr,
  input logic            reg_sel,
  input logic [IDXW-1:0] range_start,
  input logic [IDXW-1:0] range_end,
  input logic [2:0]      wp_status,
  input logic            busy,
  input logic            done,
  input logic            cmd_err
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R10

  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !done); // R10

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(wp_status) == 1); // R2

  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> $stable(wp_status)); // R7

  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_err) |-> done); // R9

  AST_ERR_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_err) |-> busy); // R9

  AST_START_COPIES_END: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr && !reg_sel) |-> (range_start == range_end)); // R8

endmodule

bind wp_lock_ctrl wp_lock_chk #(.IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .range_start (range_start),
  .range_end   (range_end),
  .wp_status   (wp_status),
  .busy        (busy),
  .done        (done),
  .cmd_err     (cmd_err)
);

// File: tb/sim_wp_lock_ctrl.sv
`timescale 1ns/1ps
module sim_wp_lock_ctrl;

  localparam int NB   = 12;
  localparam int DW   = 16;
  localparam int IW   = 4;
  localparam logic [2:0] S_T = 3'b001;
  localparam logic [2:0] S_L = 3'b010;
  localparam logic [2:0] S_U = 3'b100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_sel = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_op = 8'h00;
  logic [IW-1:0] q_idx = '0;
  logic [2:0]    q_state;
  logic [IW-1:0] range_start, range_end;
  logic [2:0]    wp_status;
  logic          busy, done, cmd_err;

  always #10 clk = ~clk;

  wp_lock_ctrl #(.NUM_BLK(NB), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .q_idx(q_idx), .q_state(q_state),
    .range_start(range_start), .range_end(range_end), .wp_status(wp_status),
    .busy(busy), .done(done), .cmd_err(cmd_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit started = 0;

  // Behavioural reference model
  logic [2:0] m_st [NB];
  logic [2:0] m_stat, m_q;
  bit m_err, m_busy, m_done;
  int m_start, m_end, m_cur, m_last, m_act;

  task automatic m_apply(input int i);
    logic [2:0] s;
    s = m_st[i];
    case (m_act)
      0: if (s != S_T) begin m_st[i] = S_U; m_stat = S_U; end
      1: if (s != S_T) begin m_st[i] = S_L; m_stat = S_L; end
      default: if (s != S_U) begin m_st[i] = S_T; m_stat = S_T; end
    endcase
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      foreach (m_st[i]) m_st[i] = S_L;
      m_stat = S_L; m_q = 3'b000;
      m_err = 0; m_busy = 0; m_done = 0;
      m_start = 0; m_end = 0; m_cur = 0; m_last = 0; m_act = 0;
    end else begin
      m_q = (int'(q_idx) < NB) ? m_st[q_idx] : 3'b000;
      m_done = 0;
      if (m_busy) begin
        if (m_cur > m_last) begin m_busy = 0; m_done = 1; end
        else if (m_cur >= NB) begin m_err = 1; m_busy = 0; m_done = 1; end
        else begin m_apply(m_cur); m_cur++; end
      end else if (cmd_valid) begin
        case (cmd_op)
          8'h23: begin m_act = 0; m_cur = m_start; m_last = m_end; m_busy = 1; m_err = 0; end
          8'h27: begin m_act = 0; m_cur = 0; m_last = NB - 1; m_busy = 1; m_err = 0; end
          8'h2a: begin m_act = 1; m_cur = m_start; m_last = m_end; m_busy = 1; m_err = 0; end
          8'h2c: begin m_act = 2; m_cur = m_start; m_last = m_end; m_busy = 1; m_err = 0; end
          default: ;
        endcase
      end
      if (reg_wr) begin
        if (!reg_sel) begin m_start = reg_wdata % 16; m_end = reg_wdata % 16; end
        else m_end = reg_wdata % 16;
      end
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp("R7",  "wp_status",   wp_status, m_stat);
      cmp("R9",  "cmd_err",     cmd_err, m_err);
      cmp("R10", "busy",        busy, m_busy);
      cmp("R10", "done",        done, m_done);
      cmp("R8",  "range_start", range_start, m_start);
      cmp("R8",  "range_end",   range_end, m_end);
      cmp("R2",  "q_state",     q_state, m_q);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      fails++;
      $display("FAIL R10 watchdog: actual=%0d cycles expected<50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic wreg(input bit sel, input int val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = DW'(val);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [7:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  task automatic rd(input int idx, input logic [2:0] exp, input string tag);
    @(negedge clk);
    q_idx = IW'(idx);
    @(negedge clk);
    cmp(tag, $sformatf("block %0d state", idx), q_state, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    cmp("R1", "status after reset", wp_status, S_L);
    cmp("R1", "busy after reset", busy, 0);
    rd(0, S_L, "R1");
    rd(11, S_L, "R1");
    rd(13, 3'b000, "R2");

    // R3: range unlock 2..5
    wreg(0, 2); wreg(1, 5);
    issue(8'h23);
    rd(1, S_L, "R3"); rd(2, S_U, "R3"); rd(5, S_U, "R3"); rd(6, S_L, "R3");
    cmp("R7", "status after unlock", wp_status, S_U);

    // R6: lock-tight 0..3 (0,1 locked -> tight; 2,3 unlocked stay)
    wreg(0, 0); wreg(1, 3);
    issue(8'h2c);
    rd(0, S_T, "R6"); rd(1, S_T, "R6"); rd(3, S_U, "R6");
    cmp("R7", "status after tight", wp_status, S_T);

    // R4: unlock all, tight blocks stay
    issue(8'h27);
    rd(0, S_T, "R4"); rd(7, S_U, "R4"); rd(11, S_U, "R4");

    // R5: lock 1..2 (1 tight stays, 2 locked)
    wreg(0, 1); wreg(1, 2);
    issue(8'h2a);
    rd(1, S_T, "R5"); rd(2, S_L, "R5");
    cmp("R7", "status after lock", wp_status, S_L);

    // R6: tight on tight block rewrites
    wreg(0, 1);
    issue(8'h2c);
    cmp("R6", "status after tight rewrite", wp_status, S_T);

    // R9: error walk 10..15 (masked from 16'hFFFF)
    wreg(0, 10); wreg(1, 16'hFFFF);
    cmp("R8", "end masked", range_end, 15);
    issue(8'h27);
    wreg(0, 10); wreg(1, 16'h00FF);
    issue(8'h2a);
    cmp("R9", "error flag", cmd_err, 1);
    rd(10, S_L, "R9"); rd(11, S_L, "R9");

    // R9: first above last touches nothing, error clears
    wreg(0, 6); wreg(1, 3);
    issue(8'h2c);
    cmp("R9", "error cleared", cmd_err, 0);
    rd(6, S_U, "R9");

    // R11: command while busy, unknown opcode
    wreg(0, 0); wreg(1, 11);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 8'h23;
    @(negedge clk); cmd_op = 8'h2a;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    rd(4, S_U, "R11");
    issue(8'h55);
    cmp("R11", "busy after unknown op", busy, 0);
    rd(4, S_U, "R11");

    // R8: mask on start write
    wreg(0, 16'h0AB3);
    cmp("R8", "start masked", range_start, 3);
    cmp("R8", "end copied", range_end, 3);
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule